// File: doc/BRIEF.md
# Memory-Mapped 16x16 Multiplier Peripheral

This block is an AXI4-Lite slave. It gives a processor a bank of four 32-bit words and an unsigned 16x16 multiplier. Software stores both operands with one 32-bit write to the operand word, one operand in each half. A single 32-bit read of the product word then returns the full 32-bit unsigned product. A register inside the block holds the product, and that register loads on every rising edge of the bus clock.

The product word is not storage. A read of it returns the registered product, and a write to it is accepted but changes nothing. The two upper words are ordinary read/write scratch words. Writes honour byte strobes. The write address and write data channels are independent, so either one may arrive first.

Top module: `axil_mult_periph`

## Requirements
- R1: While reset is low, and in the first cycle after it, BVALID and RVALID are low. After reset every word reads as 0x00000000.
- R2: The word at byte offset 0x0 reads back the value last stored there. The words at 0x8 and 0xC are plain read/write storage.
- R3: Bits 31:16 of word 0x0 form operand A and bits 15:0 form operand B, both unsigned. A read of byte offset 0x4 returns the unsigned 32-bit A*B. This value is valid from the second clock edge after the write to 0x0 completes.
- R4: A write to offset 0x4 gets an OKAY response. It does not change the product or the operand word.
- R5: WSTRB bit i enables write data bits 8i+7:8i of a write to 0x0, 0x8 or 0xC. A lane whose strobe bit is clear keeps its old contents.
- R6: AW and W handshakes are accepted independently, and either may come first. No response is given until both have been seen. BVALID then stays high until BREADY. While BVALID is high, AWREADY and WREADY are low.
- R7: RVALID rises in the cycle after the AR handshake. RVALID and RDATA then hold steady until RREADY. ARREADY is low while RVALID is high.
- R8: BRESP and RRESP are always 2'b00 (OKAY).
- R9: Address bits 3:2 select the word. Address bits 1:0 are ignored on both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_awaddr_i | input | 4 | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | 4 | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |

## Verification
The bench uses the default parameters: a 4-bit address, a 32-bit data word and four words. With these, every word and every byte lane can be reached directly, and both full-scale operands 0xFFFF can be tried, which gives the largest product 0xFFFE0001. It drives writes in three orders (address and data together, address first, data first) and holds BREADY and RREADY low for several cycles. This exercises the response hold rules and the point at which a write completes. A queue of expected read values, built from the operands the bench wrote, checks the product, the operand word, the scratch words and the strobe merges.

// File: rtl/mulreg_pkg.sv
package mulreg_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int OPND_IDX = 0;  // operand word
  localparam int PROD_IDX = 1;  // read returns product
endpackage

// File: rtl/axil_wr_chan.sv
module axil_wr_chan #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o
);
  import mulreg_pkg::*;

  logic              aw_seen_q, w_seen_q, bvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  logic              aw_hs, w_hs;

  assign awready_o = !aw_seen_q && !bvalid_q;
  assign wready_o  = !w_seen_q && !bvalid_q;
  assign aw_hs     = awvalid_i && awready_o;
  assign w_hs      = wvalid_i && wready_o;
  assign wr_en_o   = (aw_seen_q || aw_hs) && (w_seen_q || w_hs);
  assign wr_addr_o = aw_seen_q ? addr_q : awaddr_i;
  assign wr_data_o = w_seen_q ? data_q : wdata_i;
  assign wr_strb_o = w_seen_q ? strb_q : wstrb_i;
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_seen_q <= 1'b0;
      w_seen_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
    end else begin
      if (aw_hs) addr_q <= awaddr_i;
      if (w_hs) begin
        data_q <= wdata_i;
        strb_q <= wstrb_i;
      end
      if (wr_en_o) begin
        aw_seen_q <= 1'b0;
        w_seen_q  <= 1'b0;
        bvalid_q  <= 1'b1;
      end else begin
        if (aw_hs) aw_seen_q <= 1'b1;
        if (w_hs)  w_seen_q  <= 1'b1;
        if (bvalid_q && bready_i) bvalid_q <= 1'b0;
      end
    end
  end

  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o) else $error("bvalid dropped"); // R6
  AST_B_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o |-> !awready_o && !wready_o) else $error("accept during resp"); // R6
  AST_B_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> bvalid_o) else $error("no resp after write"); // R6
endmodule

// File: rtl/axil_rd_chan.sv
module axil_rd_chan #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  import mulreg_pkg::*;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ar_hs;

  assign arready_o = !rvalid_q;
  assign ar_hs     = arvalid_i && arready_o;
  assign rd_addr_o = araddr_i;
  assign rdata_o   = rdata_q;
  assign rvalid_o  = rvalid_q;
  assign rresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (ar_hs) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_data_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  AST_R_AFTER_AR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_i && arready_o |=> rvalid_o) else $error("rvalid late"); // R7
  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o)) else $error("r unstable"); // R7
endmodule

// File: rtl/mulreg_bank.sv
module mulreg_bank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int N_REGS = 4,
  localparam int STRB_W = DATA_W / 8,
  localparam int OPND_W = DATA_W / 2,
  localparam int LSB    = $clog2(STRB_W),
  localparam int IDX_W  = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [STRB_W-1:0] wr_strb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  import mulreg_pkg::*;

  logic [DATA_W-1:0] regs_q [N_REGS];
  logic [DATA_W-1:0] prod_q;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [OPND_W-1:0] opnd_a, opnd_b;
  logic              unused_bits;

  assign wr_idx = wr_addr_i[LSB +: IDX_W];
  assign rd_idx = rd_addr_i[LSB +: IDX_W];
  assign opnd_a = regs_q[OPND_IDX][DATA_W-1:OPND_W];
  assign opnd_b = regs_q[OPND_IDX][OPND_W-1:0];
  assign unused_bits = ^{wr_addr_i[LSB-1:0], rd_addr_i[LSB-1:0], regs_q[PROD_IDX]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N_REGS; r++) regs_q[r] <= '0;
    end else if (wr_en_i) begin
      for (int r = 0; r < N_REGS; r++) begin
        if (r != PROD_IDX && wr_idx == IDX_W'(r)) begin
          for (int b = 0; b < STRB_W; b++)
            if (wr_strb_i[b]) regs_q[r][8*b +: 8] <= wr_data_i[8*b +: 8];
        end
      end
    end
  end

  // registered multiplier, reloads every edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_q <= '0;
    else         prod_q <= DATA_W'(opnd_a) * DATA_W'(opnd_b);
  end

  assign rd_data_o = (rd_idx == IDX_W'(PROD_IDX)) ? prod_q : regs_q[rd_idx];

  AST_PROD_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_idx == IDX_W'(PROD_IDX) |=> $stable(prod_q)) else $error("prod moved"); // R4
  AST_OPND_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_idx == IDX_W'(PROD_IDX) |=> $stable(regs_q[OPND_IDX])) else $error("opnd moved"); // R4
  AST_NO_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q[OPND_IDX])) else $error("opnd changed w/o write"); // R2
endmodule

// File: rtl/axil_mult_periph.sv
module axil_mult_periph #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int N_REGS = 4,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DATA_W-1:0] s_wdata_i,
  input  logic [STRB_W-1:0] s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;

  axil_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr (
    .clk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wstrb_i(s_wstrb_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bresp_o(s_bresp_o), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strb_o(wr_strb)
  );

  axil_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd (
    .clk_i, .rst_ni,
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rresp_o(s_rresp_o), .rvalid_o(s_rvalid_o), .rready_i(s_rready_i),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  mulreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_REGS(N_REGS)) i_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  AST_RESP_OKAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_bvalid_o |-> s_bresp_o == 2'b00) and (s_rvalid_o |-> s_rresp_o == 2'b00))
    else $error("non-okay resp"); // R8
endmodule

// File: tb/test_axil_mult_periph.sv
`timescale 1ns/1ps
module test_axil_mult_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] op_a, op_b;
  logic [31:0] hold_v;

  always #2.5 clk = ~clk;

  axil_mult_periph i_axil_mult_periph (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data at each R handshake
  always @(negedge clk) begin
    if (rst_n && rvalid && rready) begin
      if (exp_q.size() == 0) check("R7 unexpected read", rdata, 32'hx);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata, e);
        check("R8 rresp", {30'b0, rresp}, 32'h0);
      end
    end
  end

  task automatic send_aw(input logic [3:0] a);
    awaddr = a; awvalid = 1'b1;
    forever begin @(negedge clk); if (awready) break; end
    @(posedge clk); #1 awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    wdata = d; wstrb = s; wvalid = 1'b1;
    forever begin @(negedge clk); if (wready) break; end
    @(posedge clk); #1 wvalid = 1'b0;
  endtask

  // mode 0: together, 1: AW first, 2: W first
  task automatic axi_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s, input int mode);
    @(posedge clk); #1;
    if (mode == 0) begin
      fork send_aw(a); send_w(d, s); join
    end else begin
      if (mode == 1) send_aw(a); else send_w(d, s);
      @(negedge clk); check("R6 no resp with one channel", {31'b0, bvalid}, 32'h0);
      @(posedge clk); #1;
      if (mode == 1) send_w(d, s); else send_aw(a);
    end
    forever begin @(negedge clk); if (bvalid) break; end
    check("R8 bresp", {30'b0, bresp}, 32'h0);
    @(negedge clk);
    check("R6 bvalid hold", {31'b0, bvalid}, 32'h1);
    check("R6 awready low in resp", {31'b0, awready}, 32'h0);
    @(posedge clk); #1 bready = 1'b1;
    @(posedge clk); #1 bready = 1'b0;
    @(negedge clk); check("R6 bvalid drop", {31'b0, bvalid}, 32'h0);
  endtask

  task automatic axi_read(input logic [3:0] a, input logic [31:0] exp, input string tag, input bit stall);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1 araddr = a; arvalid = 1'b1;
    forever begin @(negedge clk); if (arready) break; end
    @(posedge clk); #1 arvalid = 1'b0;
    if (!stall) begin
      rready = 1'b1;
      @(negedge clk); check("R7 rvalid next cycle", {31'b0, rvalid}, 32'h1);
      @(posedge clk); #1 rready = 1'b0;
    end else begin
      @(negedge clk); check("R7 rvalid next cycle", {31'b0, rvalid}, 32'h1);
      hold_v = rdata;
      repeat (2) begin
        @(negedge clk);
        check("R7 rvalid held", {31'b0, rvalid}, 32'h1);
        check("R7 rdata stable", rdata, hold_v);
        check("R7 arready low", {31'b0, arready}, 32'h0);
      end
      @(posedge clk); #1 rready = 1'b1;
      @(posedge clk); #1 rready = 1'b0;
    end
    @(negedge clk); check("R7 rvalid drop", {31'b0, rvalid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 bvalid in reset", {31'b0, bvalid}, 32'h0);
    check("R1 rvalid in reset", {31'b0, rvalid}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 bvalid after reset", {31'b0, bvalid}, 32'h0);
    check("R1 rvalid after reset", {31'b0, rvalid}, 32'h0);
    for (int r = 0; r < 4; r++) axi_read(4'(r * 4), 32'h0, "R1 word zero", 1'b0);

    axi_write(4'h0, 32'h0002_0003, 4'hF, 0);
    axi_read(4'h4, 32'h0000_0006, "R3 2*3", 1'b0);
    axi_read(4'h0, 32'h0002_0003, "R2 opnd readback", 1'b0);

    axi_write(4'h0, 32'hFFFF_FFFF, 4'hF, 1);
    axi_read(4'h4, 32'hFFFE_0001, "R3 max product", 1'b0);

    axi_write(4'h4, 32'h1234_5678, 4'hF, 2);
    axi_read(4'h4, 32'hFFFE_0001, "R4 prod unchanged", 1'b0);
    axi_read(4'h0, 32'hFFFF_FFFF, "R4 opnd unchanged", 1'b0);

    axi_write(4'h8, 32'hA5A5_5A5A, 4'hF, 0);
    axi_write(4'hC, 32'h0BAD_F00D, 4'hF, 1);
    axi_read(4'h8, 32'hA5A5_5A5A, "R2 scratch 8", 1'b0);
    axi_read(4'hC, 32'h0BAD_F00D, "R2 scratch C", 1'b0);

    axi_write(4'h8, 32'h1122_3344, 4'b0101, 2);
    axi_read(4'h8, 32'hA522_5A44, "R5 strobe merge", 1'b0);
    axi_write(4'h0, 32'h0000_0007, 4'b0011, 0);
    axi_read(4'h0, 32'hFFFF_0007, "R5 opnd lanes", 1'b0);
    axi_read(4'h4, 32'h0006_FFF9, "R5 R3 product after strobe", 1'b0);

    axi_read(4'h9, 32'hA522_5A44, "R9 low addr bits read", 1'b0);
    axi_write(4'hE, 32'hCAFE_0001, 4'hF, 0);
    axi_read(4'hC, 32'hCAFE_0001, "R9 low addr bits write", 1'b0);

    axi_read(4'h4, 32'h0006_FFF9, "R7 stalled read", 1'b1);

    for (int i = 0; i < 8; i++) begin
      op_a = 16'($urandom);
      op_b = 16'($urandom);
      axi_write(4'h0, {op_a, op_b}, 4'hF, i % 3);
      axi_read(4'h4, {16'h0, op_a} * {16'h0, op_b}, "R3 sweep", 1'b0);
    end

    check("R7 queue drained", 32'(exp_q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule